// File: doc/BRIEF.md
# Eight-bit Arithmetic/Logic Unit with Status Byte

This block combines an eight-bit arithmetic/logic datapath with the processor status byte that records what happened in the last operation. The first operand always comes from a register value. The second operand comes from either a second register value or an immediate. The result is combinational, so it is valid in the same cycle as the operands. The condition flags are registered, and they take their new values at the next rising clock edge. Operations fall into three groups: arithmetic (add and subtract with and without carry, negate, increment, decrement), logic (and, or, exclusive-or, complement), and bit shifts (logical right, rotate right through carry, arithmetic right).

The status byte also holds two bits that are not condition flags. The first is a global interrupt enable. It is cleared when an interrupt is taken, set by the return from an interrupt, and also controlled by explicit enable and disable strobes. The second is a bit-copy storage bit. A store strobe copies one selected register bit into it. A bit-load output always presents the first operand with the selected bit replaced by the stored bit. Because nothing saves the status byte around interrupts, a full-byte write port lets software restore it.

Top module: `alu_status_unit`

## Requirements
- R1: While reset is asserted and after its release, the status byte reads 0. Its layout from bit 7 down to bit 0 is: interrupt enable, copy bit T, half carry H, sign S, overflow V, negative N, zero Z, carry C.
- R2: The second operand is `imm_val` when `use_imm` is 1 and `rr_val` otherwise. `result` follows the operands in the same cycle. The flags change at the next rising edge, and only when `op_valid` is 1.
- R3: Opcode 0 is add and opcode 1 is add with the stored C. C takes the carry out of bit 7, H takes the carry out of bit 3, and V is set when two operands of equal sign give a result of the other sign.
- R4: Opcode 2 is subtract, opcode 3 is subtract with the stored C as borrow, and opcode 8 is negate (0 minus the first operand). C takes the borrow out of bit 7 and H takes the borrow out of bit 3. V is set when the operands differ in sign and the result's sign differs from the first operand's sign.
- R5: Opcode 9 is increment and opcode 10 is decrement. V is set when the result is 0x80 (increment) or 0x7F (decrement). C and H keep their values.
- R6: Opcodes 4, 5, 6 and 7 are and, or, exclusive-or and complement of the first operand. Each of them clears V and leaves C and H unchanged.
- R7: Opcode 11 is logical shift right, opcode 12 is rotate right with the old C entering bit 7, and opcode 13 is arithmetic shift right. C takes the old bit 0, V is set to N XOR C, and H is unchanged.
- R8: For opcodes 0 to 13, N is result bit 7, Z is set exactly when the result is 0, and S equals N XOR V.
- R9: Opcodes 14 and 15 pass the first operand to `result` and leave the flags unchanged. When `op_valid` is 0, bits 5 to 0 keep their values.
- R10: `int_take` or `ie_clr` clears bit 7. Otherwise `int_ret` or `ie_set` sets it. Clearing wins when both are requested in the same cycle.
- R11: `bst_en` copies bit `bit_sel` of `rd_val` into T. `bld_data` is `rd_val` with bit `bit_sel` replaced by T.
- R12: `sreg_wr` loads `sreg_wdata` into the whole status byte, and it overrides every other update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply the selected operation to the flags |
| op_sel | input | 4 | Operation code |
| use_imm | input | 1 | Second operand from immediate |
| rd_val | input | WIDTH | First operand |
| rr_val | input | WIDTH | Second operand, register form |
| imm_val | input | WIDTH | Second operand, immediate form |
| bit_sel | input | clog2(WIDTH) | Bit index for store/load of T |
| bst_en | input | 1 | Copy the selected bit of rd_val into T |
| int_take | input | 1 | Interrupt entry, clears enable |
| int_ret | input | 1 | Interrupt return, sets enable |
| ie_set | input | 1 | Explicit enable |
| ie_clr | input | 1 | Explicit disable |
| sreg_wr | input | 1 | Full-byte status write |
| sreg_wdata | input | 8 | Status write data |
| result | output | WIDTH | Operation result |
| bld_data | output | WIDTH | rd_val with selected bit replaced by T |
| sreg | output | 8 | Status byte |

## Verification
The bench uses the default eight-bit width. That keeps every first-operand value within reach of a full sweep: all 256 values are crossed with all sixteen opcodes and eight second-operand values chosen at the sign and nibble boundaries. Before each operation, the status byte is preloaded through the write port with a varying pattern. This lets the carry-in and the keep-unchanged paths see both values of C and H. The second operand alternates between the immediate and register forms, and the unused form carries the inverted value. Directed sequences then cover idle cycles, interrupt-enable priority, every bit position of the copy bit, and a status write that collides with all other updates.

// File: rtl/alu_status_unit.sv
`timescale 1ns/1ps
module alu_status_unit #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_valid,
  input  logic [3:0]               op_sel,
  input  logic                     use_imm,
  input  logic [WIDTH-1:0]         rd_val,
  input  logic [WIDTH-1:0]         rr_val,
  input  logic [WIDTH-1:0]         imm_val,
  input  logic [$clog2(WIDTH)-1:0] bit_sel,
  input  logic                     bst_en,
  input  logic                     int_take,
  input  logic                     int_ret,
  input  logic                     ie_set,
  input  logic                     ie_clr,
  input  logic                     sreg_wr,
  input  logic [7:0]               sreg_wdata,
  output logic [WIDTH-1:0]         result,
  output logic [WIDTH-1:0]         bld_data,
  output logic [7:0]               sreg
);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  localparam logic [3:0] OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_EOR = 4'd6,  OP_COM = 4'd7;
  localparam logic [3:0] OP_NEG = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_LSR = 4'd11;
  localparam logic [3:0] OP_ROR = 4'd12, OP_ASR = 4'd13;

  localparam int F_C = 0, F_Z = 1, F_N = 2, F_V = 3, F_S = 4, F_H = 5, F_T = 6, F_I = 7;

  logic [7:0]       sreg_q, sreg_d;
  logic [WIDTH-1:0] opb, ax, ay, res;
  logic [WIDTH:0]   sum;
  logic             ci, is_sub, half_cy, v_arith, nf, zf;

  assign opb = use_imm ? imm_val : rr_val;

  always_comb begin
    ax = rd_val;
    ay = opb;
    ci = 1'b0;
    is_sub = 1'b0;
    case (op_sel)
      OP_ADC: ci = sreg_q[F_C];
      OP_SUB: is_sub = 1'b1;
      OP_SBC: begin is_sub = 1'b1; ci = sreg_q[F_C]; end
      OP_NEG: begin ax = '0; ay = rd_val; is_sub = 1'b1; end
      OP_INC: ay = ONE;
      OP_DEC: begin ay = ONE; is_sub = 1'b1; end
      default: ;
    endcase
  end

  assign sum = is_sub ? ({1'b0, ax} - {1'b0, ay} - {{WIDTH{1'b0}}, ci})
                      : ({1'b0, ax} + {1'b0, ay} + {{WIDTH{1'b0}}, ci});

  assign half_cy = ax[HALF] ^ ay[HALF] ^ sum[HALF];
  assign v_arith = is_sub ? ((ax[MSB] != ay[MSB]) && (sum[MSB] != ax[MSB]))
                          : ((ax[MSB] == ay[MSB]) && (sum[MSB] != ax[MSB]));

  always_comb begin
    case (op_sel)
      OP_AND:  res = rd_val & opb;
      OP_OR:   res = rd_val | opb;
      OP_EOR:  res = rd_val ^ opb;
      OP_COM:  res = ~rd_val;
      OP_LSR:  res = {1'b0, rd_val[MSB:1]};
      OP_ROR:  res = {sreg_q[F_C], rd_val[MSB:1]};
      OP_ASR:  res = {rd_val[MSB], rd_val[MSB:1]};
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: res = sum[MSB:0];
      default: res = rd_val;
    endcase
  end

  assign result = res;
  assign nf = res[MSB];
  assign zf = (res == '0);

  always_comb begin
    sreg_d = sreg_q;
    if (op_valid) begin
      case (op_sel)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
          sreg_d[F_C] = sum[WIDTH];
          sreg_d[F_H] = half_cy;
          sreg_d[F_V] = v_arith;
        end
        OP_INC, OP_DEC: sreg_d[F_V] = v_arith;
        OP_AND, OP_OR, OP_EOR, OP_COM: sreg_d[F_V] = 1'b0;
        OP_LSR, OP_ROR, OP_ASR: begin
          sreg_d[F_C] = rd_val[0];
          sreg_d[F_V] = nf ^ rd_val[0];
        end
        default: ;
      endcase
      if (op_sel < 4'd14) begin
        sreg_d[F_N] = nf;
        sreg_d[F_Z] = zf;
        sreg_d[F_S] = nf ^ sreg_d[F_V];
      end
    end
    if (bst_en) sreg_d[F_T] = rd_val[bit_sel];
    if (int_take || ie_clr) sreg_d[F_I] = 1'b0;
    else if (int_ret || ie_set) sreg_d[F_I] = 1'b1;
    if (sreg_wr) sreg_d = sreg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign sreg = sreg_q;

  always_comb begin
    bld_data = rd_val;
    bld_data[bit_sel] = sreg_q[F_T];
  end

  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel < 4'd14 && !sreg_wr) |=> (sreg[F_S] == (sreg[F_N] ^ sreg[F_V]))); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel < 4'd14 && !sreg_wr) |=> (sreg[F_Z] == ($past(result) == '0))); // R8
  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel[3:2] == 2'b01 && !sreg_wr) |=>
      (!sreg[F_V] && sreg[F_C] == $past(sreg[F_C]) && sreg[F_H] == $past(sreg[F_H]))); // R6
  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel >= 4'd11 && op_sel <= 4'd13 && !sreg_wr) |=> (sreg[F_C] == $past(rd_val[0]))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((!op_valid || op_sel[3:1] == 3'b111) && !sreg_wr) |=> $stable(sreg[5:0])); // R9
  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_take || ie_clr) && !sreg_wr) |=> !sreg[F_I]); // R10
  AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_ret || ie_set) && !int_take && !ie_clr && !sreg_wr) |=> sreg[F_I]); // R10
  AST_BIT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_en && !sreg_wr) |=> (sreg[F_T] == $past(rd_val[bit_sel]))); // R11
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_wr |=> (sreg == $past(sreg_wdata))); // R12
endmodule

// File: tb/alu_status_unit_tb_top.sv
`timescale 1ns/1ps
module alu_status_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0, use_imm = 1'b0, bst_en = 1'b0;
  logic       int_take = 1'b0, int_ret = 1'b0, ie_set = 1'b0, ie_clr = 1'b0;
  logic       sreg_wr = 1'b0;
  logic [3:0] op_sel = '0;
  logic [7:0] rd_val = '0, rr_val = '0, imm_val = '0, sreg_wdata = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] result, bld_data, sreg;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_status_unit #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .use_imm(use_imm),
    .rd_val(rd_val), .rr_val(rr_val), .imm_val(imm_val), .bit_sel(bit_sel), .bst_en(bst_en),
    .int_take(int_take), .int_ret(int_ret), .ie_set(ie_set), .ie_clr(ie_clr),
    .sreg_wr(sreg_wr), .sreg_wdata(sreg_wdata), .result(result), .bld_data(bld_data), .sreg(sreg));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] s);
    logic [7:0] r;
    logic c, h, v, n, z, upd;
    logic [8:0] wide;
    c = s[0]; h = s[5]; v = s[3]; upd = 1'b1; r = a;
    case (op)
      4'd0, 4'd1: begin
        wide = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? {8'd0, s[0]} : 9'd0);
        r = wide[7:0]; c = wide[8];
        h = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + ((op == 4'd1) ? {4'd0, s[0]} : 5'd0)) > 5'd15;
        v = (a[7] & b[7] & ~r[7]) | (~a[7] & ~b[7] & r[7]);
      end
      4'd2, 4'd3: begin
        wide = {1'b0, b} + ((op == 4'd3) ? {8'd0, s[0]} : 9'd0);
        r = a - wide[7:0];
        c = {1'b0, a} < wide;
        h = {1'b0, a[3:0]} < ({1'b0, b[3:0]} + ((op == 4'd3) ? {4'd0, s[0]} : 5'd0));
        v = (a[7] & ~b[7] & ~r[7]) | (~a[7] & b[7] & r[7]);
      end
      4'd4: begin r = a & b; v = 1'b0; end
      4'd5: begin r = a | b; v = 1'b0; end
      4'd6: begin r = a ^ b; v = 1'b0; end
      4'd7: begin r = ~a; v = 1'b0; end
      4'd8: begin r = 8'd0 - a; c = (a != 0); h = (a[3:0] != 0); v = (r == 8'h80); end
      4'd9: begin r = a + 8'd1; v = (r == 8'h80); end
      4'd10: begin r = a - 8'd1; v = (r == 8'h7F); end
      4'd11: begin r = a >> 1; c = a[0]; v = a[0]; end
      4'd12: begin r = {s[0], a[7:1]}; c = a[0]; v = s[0] ^ a[0]; end
      4'd13: begin r = {a[7], a[7:1]}; c = a[0]; v = a[7] ^ a[0]; end
      default: upd = 1'b0;
    endcase
    n = r[7]; z = (r == 0);
    if (upd) return {r, s[7:6], h, n ^ v, v, n, z, c};
    return {r, s};
  endfunction

  function automatic string tag(input logic [3:0] op);
    if (op <= 4'd1) return "R3";
    if (op <= 4'd3 || op == 4'd8) return "R4";
    if (op <= 4'd7) return "R6";
    if (op <= 4'd10) return "R5";
    if (op <= 4'd13) return "R7";
    return "R9";
  endfunction

  function automatic logic [7:0] bval(input int i);
    case (i)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h0F; 3: return 8'h7F;
      4: return 8'h80; 5: return 8'hFF; 6: return 8'h55; default: return 8'hA8;
    endcase
  endfunction

  task automatic run_vec(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic imm, input logic [7:0] preset);
    logic [15:0] exp;
    sreg_wr = 1'b1; sreg_wdata = preset; op_valid = 1'b0;
    @(negedge clk);
    sreg_wr = 1'b0; op_valid = 1'b1; op_sel = op; rd_val = a; use_imm = imm;
    if (imm) begin imm_val = b; rr_val = ~b; end
    else begin rr_val = b; imm_val = ~b; end
    exp = model(op, a, b, preset);
    #1 chk({tag(op), imm ? " result R2" : " result"}, result, exp[15:8]);
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag(op), " flags R8"}, sreg, exp[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    sreg_wdata = 8'hFF; sreg_wr = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 during reset", sreg, 8'h00);
    sreg_wr = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", sreg, 8'h00);

    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi < 8; bi++)
          run_vec(4'(op), 8'(a), bval(bi), bi[0], 8'((a * 7 + bi * 29 + op * 3)) & 8'h3F);

    // R9: idle cycles keep flags
    sreg_wr = 1'b1; sreg_wdata = 8'h2A;
    @(negedge clk);
    sreg_wr = 1'b0; op_valid = 1'b0; op_sel = 4'd0; rd_val = 8'hFF; rr_val = 8'h01; use_imm = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 idle hold", sreg, 8'h2A);
    chk("R2 comb result while idle", result, 8'h00);

    // R10: interrupt enable control
    ie_set = 1'b1; @(negedge clk); ie_set = 1'b0;
    chk("R10 enable set", sreg, 8'hAA);
    int_take = 1'b1; @(negedge clk); int_take = 1'b0;
    chk("R10 interrupt entry", sreg, 8'h2A);
    int_ret = 1'b1; @(negedge clk); int_ret = 1'b0;
    chk("R10 interrupt return", sreg, 8'hAA);
    ie_clr = 1'b1; @(negedge clk); ie_clr = 1'b0;
    chk("R10 explicit disable", sreg, 8'h2A);
    ie_set = 1'b1; int_take = 1'b1; @(negedge clk); ie_set = 1'b0; int_take = 1'b0;
    chk("R10 clear beats set", sreg, 8'h2A);
    int_ret = 1'b1; ie_clr = 1'b1; @(negedge clk); int_ret = 1'b0; ie_clr = 1'b0;
    chk("R10 disable beats return", sreg, 8'h2A);

    // R11: bit store and bit load at every position
    for (int k = 0; k < 8; k++) begin
      bit_sel = 3'(k);
      rd_val = 8'(1 << k); bst_en = 1'b1;
      @(negedge clk);
      chk("R11 store one", sreg, 8'h6A);
      rd_val = 8'h00; bst_en = 1'b0;
      #1 chk("R11 load one", bld_data, 8'(1 << k));
      rd_val = ~8'(1 << k); bst_en = 1'b1;
      @(negedge clk);
      bst_en = 1'b0;
      chk("R11 store zero", sreg, 8'h2A);
      rd_val = 8'hFF;
      #1 chk("R11 load zero", bld_data, ~8'(1 << k));
      @(negedge clk);
    end

    // R12: write overrides every other update
    op_valid = 1'b1; op_sel = 4'd0; rd_val = 8'h80; rr_val = 8'h80;
    bst_en = 1'b1; bit_sel = 3'd7; int_ret = 1'b1;
    sreg_wr = 1'b1; sreg_wdata = 8'h15;
    @(negedge clk);
    op_valid = 1'b0; bst_en = 1'b0; int_ret = 1'b0; sreg_wr = 1'b0;
    chk("R12 write wins", sreg, 8'h15);
    sreg_wr = 1'b1; sreg_wdata = 8'hC0; int_take = 1'b1;
    @(negedge clk);
    sreg_wr = 1'b0; int_take = 1'b0;
    chk("R12 write beats entry", sreg, 8'hC0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule